// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the access address for a burst-capable synchronous SRAM port. On every enabled clock it does one of two things. It can take a fresh starting address from the external bus. Or it can step a small internal burst counter and drive an address derived from that counter. The resulting address is registered and is the one used for that cycle's read or write. Read bursts and write bursts use the same sequence, and a new burst may begin on the cycle right after any step.

The bits above the burst field are frozen at their loaded value for the whole burst. The low burst bits follow one of two orders. The linear order adds the burst count to the start value, wrapping inside the burst field. The interleaved order XORs the start value with the burst count. A mode input selects the order. It is treated as static configuration and is sampled only when a burst is loaded. A burst covers four addresses: the loaded one and three more. The next step after the fourth address returns to the loaded start.

Top module: `burst_addr_gen`

## Requirements
- R1: On a rising edge with `clkEn` high and `advance` low, `addrOut` becomes `addrIn` and the burst count restarts at 0.
- R2: On a rising edge with `clkEn` high and `advance` high, `addrOut` takes the counter-derived address and `addrIn` has no effect on it.
- R3: With the default 2-bit burst field, the fourth step after a load drives the loaded start address again, and later steps repeat the same four-address cycle.
- R4: During steps, the bits of `addrOut` above the 2-bit burst field keep their loaded value and never receive a carry from the burst field.
- R5: If `interleaved` was 0 at load, step k (counting from 1) drives low bits equal to (start + k) mod 4. For example, a start of 2 gives 2, 3, 0, 1.
- R6: If `interleaved` was 1 at load, step k drives low bits equal to start XOR (k mod 4). For example, a start of 1 gives 1, 0, 3, 2, and a start of 3 gives 3, 2, 1, 0.
- R7: While `clkEn` is low, `addrOut` and the burst count hold their values whatever `advance`, `interleaved` and `addrIn` do.
- R8: A rising edge with `rst` high clears `addrOut`, the stored start and the burst count to 0, and selects linear order. Steps with no prior load therefore drive 1, 2, 3, 0.
- R9: A change of `interleaved` after a load does not change the order of the running burst. The new value takes effect at the next load.
- R10: A load may follow any step directly. That load's address appears on the next edge, and the following steps sequence from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clkEn | input | 1 | Clock enable; low holds all state |
| advance | input | 1 | 1 = step the burst counter, 0 = load `addrIn` |
| interleaved | input | 1 | Order select sampled at load: 0 linear, 1 interleaved |
| addrIn | input | ADDR_W | External starting address |
| addrOut | output | ADDR_W | Registered address for this cycle's access |

## Verification
The assertions assume that `interleaved` is a configuration level. They judge the order of a step only from the mode captured at the latest load, and never from the live input. They also assume that `addrIn` may carry any value during steps, so they compare the upper bits against the previous output rather than against the bus. The stimulus changes `interleaved` only between bursts, except in one directed test that flips it in the middle of a burst to show that the latched order wins. During steps it drives the inverted start address on `addrIn`, so any leak from the bus would show up at the output.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

  // Strobes issued by the control half to the datapath half.
  typedef struct packed {
    logic clear;  // synchronous reset of all state
    logic load;   // capture a new start address
    logic step;   // advance the burst counter
  } burstStrobe_t;

endpackage

// File: rtl/burst_order.sv
// Combinational order logic: maps start value and burst count to low bits.
module burst_order #(
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0] startLow,
  input  logic [CNT_W-1:0] count,
  input  logic             interleaved,
  output logic [CNT_W-1:0] orderLow
);

  logic [CNT_W-1:0] linearLow;
  logic [CNT_W-1:0] xorLow;

  // Linear: modular add inside the burst field, no carry out.
  assign linearLow = startLow + count;

  // Interleaved: bitwise XOR of start and count.
  genvar b;
  generate
    for (b = 0; b < CNT_W; b++) begin : gXor
      assign xorLow[b] = startLow[b] ^ count[b];
    end
  endgenerate

  always_comb begin
    if (interleaved) orderLow = xorLow;
    else             orderLow = linearLow;
  end

endmodule

// File: rtl/burst_ctrl.sv
// Control: decodes reset, enable and advance into datapath strobes.
module burst_ctrl
  import burst_addr_pkg::*;
(
  input  logic         rst,
  input  logic         clkEn,
  input  logic         advance,
  output burstStrobe_t strobe
);

  always_comb begin
    strobe       = '0;
    strobe.clear = rst;
    if (!rst && clkEn) begin
      strobe.load = !advance;
      strobe.step = advance;
    end
  end

endmodule

// File: rtl/burst_datapath.sv
// Datapath: start register, burst counter, latched mode and output register.
module burst_datapath
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  burstStrobe_t      strobe,
  input  logic              interleaved,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] addrOut,
  output logic              modeQ
);

  localparam int HI_W = ADDR_W - CNT_W;

  logic [ADDR_W-1:0] startQ;
  logic [CNT_W-1:0]  countQ;
  logic [CNT_W-1:0]  countNext;
  logic [CNT_W-1:0]  orderLow;
  logic [ADDR_W-1:0] addrQ;
  logic [HI_W-1:0]   startHigh;

  assign countNext = countQ + 1'b1;
  assign startHigh = startQ[ADDR_W-1:CNT_W];

  burst_order #(.CNT_W(CNT_W)) uOrder (
    .startLow   (startQ[CNT_W-1:0]),
    .count      (countNext),
    .interleaved(modeQ),
    .orderLow   (orderLow)
  );

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      startQ <= '0;
      countQ <= '0;
      modeQ  <= 1'b0;
      addrQ  <= '0;
    end else if (strobe.load) begin
      startQ <= addrIn;
      countQ <= '0;
      modeQ  <= interleaved;
      addrQ  <= addrIn;
    end else if (strobe.step) begin
      countQ <= countNext;
      addrQ  <= {startHigh, orderLow};
    end
  end

  assign addrOut = addrQ;

endmodule

// File: rtl/burst_addr_gen.sv
// Top: thin wrapper joining control and datapath.
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clkEn,
  input  logic              advance,
  input  logic              interleaved,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] addrOut
);

  burstStrobe_t strobe;
  logic         modeQ;

  burst_ctrl uCtrl (
    .rst    (rst),
    .clkEn  (clkEn),
    .advance(advance),
    .strobe (strobe)
  );

  burst_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uData (
    .clk        (clk),
    .strobe     (strobe),
    .interleaved(interleaved),
    .addrIn     (addrIn),
    .addrOut    (addrOut),
    .modeQ      (modeQ)
  );

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              clkEn,
  input logic              advance,
  input logic [ADDR_W-1:0] addrIn,
  input logic [ADDR_W-1:0] addrOut,
  input logic              modeQ
);

  // R8: reset clears the output
  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> addrOut == '0);

  // R1: load captures the bus
  a_r1_load_captures: assert property (@(posedge clk) disable iff (rst)
    (clkEn && !advance) |=> addrOut == $past(addrIn));

  // R7: disabled clock holds the output
  a_r7_hold_when_off: assert property (@(posedge clk) disable iff (rst)
    !clkEn |=> $stable(addrOut));

  // R4: steps never alter the upper bits
  a_r4_upper_fixed: assert property (@(posedge clk) disable iff (rst)
    (clkEn && advance) |=> addrOut[ADDR_W-1:CNT_W] == $past(addrOut[ADDR_W-1:CNT_W]));

  // R5: linear step adds one inside the burst field
  a_r5_linear_step: assert property (@(posedge clk) disable iff (rst)
    (clkEn && advance && !modeQ) |=>
      addrOut[CNT_W-1:0] == CNT_W'($past(addrOut[CNT_W-1:0]) + 1'b1));

  // R6: interleaved step always changes the low bits
  a_r6_xor_step_moves: assert property (@(posedge clk) disable iff (rst)
    (clkEn && advance && modeQ) |=>
      $countones(addrOut[CNT_W-1:0] ^ $past(addrOut[CNT_W-1:0])) != 0);

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uChk (
  .clk    (clk),
  .rst    (rst),
  .clkEn  (clkEn),
  .advance(advance),
  .addrIn (addrIn),
  .addrOut(addrOut),
  .modeQ  (modeQ)
);

// File: tb/burst_addr_gen_test.sv
`timescale 1ns/1ps
module burst_addr_gen_test;

  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clkEn = 1'b0;
  logic          advance = 1'b0;
  logic          interleaved = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic [AW-1:0] addrOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .CNT_W(2)) uut (
    .clk(clk), .rst(rst), .clkEn(clkEn), .advance(advance),
    .interleaved(interleaved), .addrIn(addrIn), .addrOut(addrOut)
  );

  // Table: {mode, start address}; every start value in both orders.
  localparam logic [AW:0] VEC [8] = '{
    {1'b0, 20'hA5C30}, {1'b0, 20'h3F101}, {1'b0, 20'hFFFF2}, {1'b0, 20'h00003},
    {1'b1, 20'h5A3C0}, {1'b1, 20'hC0DE1}, {1'b1, 20'h7777E}, {1'b1, 20'hFFFFF}
  };

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: addrOut=%h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic r, input logic en, input logic adv,
                     input logic md, input logic [AW-1:0] a);
    @(negedge clk);
    rst = r; clkEn = en; advance = adv; interleaved = md; addrIn = a;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [AW-1:0] refAddr(input logic [AW-1:0] st, input logic md, input int k);
    logic [1:0] kk;
    logic [1:0] lo;
    kk = 2'(k);
    lo = md ? (st[1:0] ^ kk) : 2'(st[1:0] + kk);
    return {st[AW-1:2], lo};
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: addrOut=%h expected end of run", addrOut);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    // R8: reset state, with mode input high and garbage bus
    cyc(1, 1, 0, 1, 20'h12345);
    cyc(1, 1, 1, 1, 20'hABCDE);
    check("R8 reset", addrOut, '0);
    for (int k = 1; k <= 4; k++) begin
      cyc(0, 1, 1, 1, 20'hFFFFF);
      check("R8 step from reset linear", addrOut, 20'(k % 4));
    end

    // R1..R6: all start values, both orders, two full wraps
    for (int i = 0; i < 8; i++) begin
      logic [AW-1:0] st;
      logic md;
      st = VEC[i][AW-1:0];
      md = VEC[i][AW];
      cyc(0, 1, 0, md, st);
      check("R1 load", addrOut, st);
      for (int k = 1; k <= 8; k++) begin
        cyc(0, 1, 1, md, ~st);
        if (k % 4 == 0)  check("R3 wrap to start", addrOut, st);
        else if (md)     check("R6 interleaved R2 R4", addrOut, refAddr(st, md, k));
        else             check("R5 linear R2 R4", addrOut, refAddr(st, md, k));
      end
    end

    // R7: clock enable low holds state
    cyc(0, 1, 0, 0, 20'hABCD1);
    cyc(0, 1, 1, 0, 20'h0);
    check("R7 setup", addrOut, 20'hABCD2);
    cyc(0, 0, 1, 1, 20'h11111);
    check("R7 hold on advance", addrOut, 20'hABCD2);
    cyc(0, 0, 0, 1, 20'h22222);
    check("R7 hold on load", addrOut, 20'hABCD2);
    cyc(0, 1, 1, 0, 20'h0);
    check("R7 counter held", addrOut, 20'hABCD3);

    // R9: mode change mid-burst ignored until next load
    cyc(0, 1, 0, 0, 20'h40000);
    cyc(0, 1, 1, 1, 20'h0);
    check("R9 latched linear 1", addrOut, 20'h40001);
    cyc(0, 1, 1, 1, 20'h0);
    check("R9 latched linear 2", addrOut, 20'h40002);
    cyc(0, 1, 0, 1, 20'h40001);
    cyc(0, 1, 1, 0, 20'h0);
    check("R9 new mode at load", addrOut, 20'h40000);

    // R10: back to back loads and load right after a step
    cyc(0, 1, 0, 0, 20'h12342);
    cyc(0, 1, 0, 0, 20'h98763);
    check("R10 load after load", addrOut, 20'h98763);
    cyc(0, 1, 1, 0, 20'h0);
    check("R10 R4 no carry", addrOut, 20'h98760);
    cyc(0, 1, 0, 1, 20'h55552);
    check("R10 load after step", addrOut, 20'h55552);
    cyc(0, 1, 1, 1, 20'h0);
    check("R10 step from new start", addrOut, 20'h55553);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule